// File: doc/BRIEF.md
# Flash Erase Block Select Registers

This block holds the erase target for an on-chip flash array of twelve blocks. Two byte-wide control registers are accessed through a small synchronous port. The low register holds select bits for blocks 7..0. The high register holds select bits for blocks 11..8 in its low nibble. The flash controller receives a registered one-hot vector, `erase_en_o`. Only the block whose bit is set there may be erased, and every other block stays protected. To erase the whole array, software selects one block at a time and erases each in turn.

Several conditions wipe both registers:
- system reset;
- a standby indication;
- the hardware write-enable pin held low;
- that pin high while the software write-enable bit is clear.

While any of these holds, writes have no effect. A flash-disabled flag masks register reads and the output vector to zero. A restricted-mode flag stops software from setting any bit. A write that would leave more than one select bit set across both registers is refused. The refused write sets a sticky error flag, and software clears that flag by writing 1 to bit 7 of the high register.

Top module: `flash_erase_select`

## Requirements
- R1: Address 0 is the low register. Bits 7..0 select blocks 7..0, are read/write, and reset to 0.
- R2: Address 1 is the high register. Bits 3..0 select blocks 11..8. Bits 7..4 always read as 0.
- R3: Reset (`rst_n` low), `standby_i` high or `fwe_pin_i` low clears both registers. `erase_en_o` is zero from the next clock edge on.
- R4: While `fwe_pin_i` is high and `swe_i` is low, both registers are cleared and writes have no effect.
- R5: Bit n of `erase_en_o` enables block n only. It updates on the clock edge that accepts a write, and at most one bit is ever set.
- R6: While `flash_off_i` is high, `rdata_o` reads 0x00. `erase_en_o` is all zeros from the next edge on, and the stored register values are kept.
- R7: While `restrict_i` is high, a write cannot set any bit. It can still clear bits.
- R8: A write that would leave more than one select bit set across both registers is rejected. The old value is kept and `err_o` becomes 1 on the next edge.
- R9: Writing 1 to bit 7 at address 1 clears `err_o`, unless the same write is rejected, in which case `err_o` stays 1. Reset clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| standby_i | input | 1 | Standby indication (hardware or software) |
| fwe_pin_i | input | 1 | Hardware flash write-enable pin |
| swe_i | input | 1 | Software write-enable bit |
| flash_off_i | input | 1 | Flash disabled |
| restrict_i | input | 1 | Restricted mode: no bit may be set |
| addr_i | input | 1 | Register select: 0 low, 1 high |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data of the addressed register |
| erase_en_o | output | 12 | Registered one-hot erase enable |
| err_o | output | 1 | Sticky rejected-write flag |

## Verification
A wrong stored selection shows up in two places: in `erase_en_o` on the clock edge after the bad update, and in `rdata_o` as soon as the affected register is addressed. A missed clear condition leaves stale bits visible at both outputs within one cycle. A wrongly accepted multi-bit write breaks the one-hot property of the output at once. A wrongly refused write leaves `err_o` raised and the old selection in place. Comparing against a cycle model on every clock therefore catches each fault within one cycle of its cause.

// File: rtl/flash_erase_select.sv
module flash_erase_select #(
  parameter int BLOCKS = 12,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              fwe_pin_i,
  input  logic              swe_i,
  input  logic              flash_off_i,
  input  logic              restrict_i,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [BLOCKS-1:0] erase_en_o,
  output logic              err_o
);
  localparam int HI = BLOCKS - DW;

  logic [BLOCKS-1:0] sel_q, cand, sel_d;
  logic              err_q;

  wire wipe   = standby_i | ~fwe_pin_i | ~swe_i;
  wire wr_ok  = wr_i & ~wipe;

  always_comb begin
    cand = sel_q;
    if (addr_i) cand[BLOCKS-1:DW] = wdata_i[HI-1:0];
    else        cand[DW-1:0]      = wdata_i;
    if (restrict_i) cand = cand & sel_q;
  end

  wire multi   = $countones(cand) > 1;
  wire err_set = wr_ok & multi;
  wire err_clr = wr_ok & addr_i & wdata_i[DW-1];

  always_comb begin
    if (wipe)                sel_d = '0;
    else if (wr_ok & ~multi) sel_d = cand;
    else                     sel_d = sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      err_q      <= 1'b0;
      erase_en_o <= '0;
    end else begin
      sel_q      <= sel_d;
      err_q      <= err_set | (err_q & ~err_clr);
      erase_en_o <= flash_off_i ? '0 : sel_d;
    end
  end

  assign err_o   = err_q;
  assign rdata_o = flash_off_i ? '0 :
                   addr_i      ? DW'(sel_q[BLOCKS-1:DW]) : sel_q[DW-1:0];
endmodule

// File: rtl/flash_erase_select_chk.sv
module flash_erase_select_chk #(
  parameter int BLOCKS = 12,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby_i,
  input logic              fwe_pin_i,
  input logic              swe_i,
  input logic              flash_off_i,
  input logic              addr_i,
  input logic              wr_i,
  input logic [DW-1:0]     rdata_o,
  input logic [BLOCKS-1:0] erase_en_o,
  input logic              err_o
);
  AST_ONE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(erase_en_o)); // R5

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_i || !fwe_pin_i) |=> (erase_en_o == '0)); // R3

  AST_SWE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fwe_pin_i && !swe_i) |=> (erase_en_o == '0)); // R4

  AST_OFF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    flash_off_i |=> (erase_en_o == '0)); // R6

  AST_HIGH_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i |-> (rdata_o[DW-1:BLOCKS-DW] == '0)); // R2

  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(wr_i)); // R8
endmodule

bind flash_erase_select flash_erase_select_chk #(.BLOCKS(BLOCKS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .fwe_pin_i(fwe_pin_i),
  .swe_i(swe_i), .flash_off_i(flash_off_i), .addr_i(addr_i), .wr_i(wr_i),
  .rdata_o(rdata_o), .erase_en_o(erase_en_o), .err_o(err_o)
);

// File: tb/tb_flash_erase_select.sv
module tb_flash_erase_select;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, standby, fwe, swe, off, restr, addr, wr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [11:0] een;
  logic        err;

  int checks = 0, bad = 0;
  bit done = 0;

  logic [11:0] m_sel = '0;
  logic [11:0] m_out = '0;
  logic        m_err = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  flash_erase_select dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .fwe_pin_i(fwe), .swe_i(swe),
    .flash_off_i(off), .restrict_i(restr), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .erase_en_o(een), .err_o(err)
  );

  function automatic int ones(input logic [11:0] v);
    int n = 0;
    for (int i = 0; i < 12; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic model_edge();
    logic [11:0] c;
    bit blocked;
    if (!rst_n) begin
      m_sel = '0; m_err = 1'b0; m_out = '0;
      return;
    end
    blocked = standby || !fwe || !swe;
    if (blocked) begin
      m_sel = '0;
    end else if (wr) begin
      c = m_sel;
      if (addr) c[11:8] = wdata[3:0]; else c[7:0] = wdata;
      if (restr) c = c & m_sel;
      if (ones(c) > 1) m_err = 1'b1;
      else begin
        m_sel = c;
        if (addr && wdata[7]) m_err = 1'b0;
      end
    end
    m_out = off ? 12'h000 : m_sel;
  endtask

  task automatic check(input string tag);
    logic [7:0] exp_rd;
    exp_rd = off ? 8'h00 : (addr ? {4'h0, m_sel[11:8]} : m_sel[7:0]);
    checks++;
    if (rdata !== exp_rd) begin
      bad++; $display("FAIL %s rdata=%h expected=%h", tag, rdata, exp_rd);
    end
    checks++;
    if (een !== m_out) begin
      bad++; $display("FAIL %s erase_en=%h expected=%h", tag, een, m_out);
    end
    checks++;
    if (err !== m_err) begin
      bad++; $display("FAIL %s err=%b expected=%b", tag, err, m_err);
    end
  endtask

  task automatic step(input string tag, input logic a, input logic w, input logic [7:0] d);
    addr = a; wr = w; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr = 1'b0;
    check(tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; standby = 1'b0; fwe = 1'b1; swe = 1'b1; off = 1'b0; restr = 1'b0;
    addr = 1'b0; wr = 1'b0; wdata = '0;
    step("R3 reset", 1'b0, 1'b0, 8'h00);
    step("R3 reset high reg", 1'b1, 1'b0, 8'h00);
    rst_n = 1'b1;
    step("R1 write low bit2", 1'b0, 1'b1, 8'h04);
    step("R5 output bit2", 1'b0, 1'b0, 8'h00);
    step("R8 second bit rejected", 1'b1, 1'b1, 8'h02);
    step("R8 old value kept", 1'b0, 1'b0, 8'h00);
    step("R1 clear low", 1'b0, 1'b1, 8'h00);
    step("R9 set EB11 and clear err", 1'b1, 1'b1, 8'hF8);
    step("R2 upper reads zero", 1'b1, 1'b0, 8'h00);
    step("R8 two bits low rejected", 1'b0, 1'b1, 8'h03);
    step("R9 rejected write keeps err", 1'b1, 1'b1, 8'h83);
    step("R9 clear err", 1'b1, 1'b1, 8'h88);
    step("R2 move to EB8", 1'b1, 1'b1, 8'h01);
    step("R1 low empty", 1'b0, 1'b0, 8'h00);
    swe = 1'b0;
    step("R4 swe low clears", 1'b1, 1'b0, 8'h00);
    step("R4 write ignored", 1'b0, 1'b1, 8'h10);
    step("R4 still zero", 1'b0, 1'b0, 8'h00);
    swe = 1'b1;
    step("R1 write bit7", 1'b0, 1'b1, 8'h80);
    fwe = 1'b0;
    step("R3 fwe low clears", 1'b0, 1'b0, 8'h00);
    fwe = 1'b1;
    step("R1 write bit0", 1'b0, 1'b1, 8'h01);
    standby = 1'b1;
    step("R3 standby clears", 1'b0, 1'b0, 8'h00);
    standby = 1'b0;
    step("R2 write EB10", 1'b1, 1'b1, 8'h04);
    off = 1'b1;
    step("R6 off masks high", 1'b1, 1'b0, 8'h00);
    step("R6 off masks low", 1'b0, 1'b0, 8'h00);
    off = 1'b0;
    step("R6 value kept after off", 1'b1, 1'b0, 8'h00);
    restr = 1'b1;
    step("R7 cannot move to EB9", 1'b1, 1'b1, 8'h02);
    step("R7 cannot set low", 1'b0, 1'b1, 8'h20);
    step("R7 can clear", 1'b1, 1'b1, 8'h00);
    step("R7 stays clear", 1'b1, 1'b0, 8'h00);
    restr = 1'b0;
    step("R5 set EB6", 1'b0, 1'b1, 8'h40);
    rst_n = 1'b0;
    step("R3 mid reset", 1'b0, 1'b0, 8'h00);
    rst_n = 1'b1;
    step("R3 after reset", 1'b0, 1'b0, 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule